// File: doc/BRIEF.md
# Page-Mode Nibble DRAM Write Controller

This block turns a stream of write beats from a host into page-mode write cycles on an external DRAM that has a 4-bit data bus and a 9-bit multiplexed address bus. Each beat carries one nibble. The first beat of a burst also carries an 18-bit word address, whose upper nine bits select the row and whose lower nine bits select the starting column. Every further beat of the burst goes to the next column of the same row. Row strobe, column strobe and write enable are active-low. RAS-to-CAS delay, CAS low time, RAS precharge and refresh hold are set in clock cycles by parameters.

After a burst the row is left open. A following burst that targets the same row reuses it without a new RAS pulse. A burst to a different row first releases RAS, waits out the precharge time and then strobes the new row. A refresh request is a level that the host holds until it sees a one-cycle acknowledge. It is only served between bursts. The refresh closes any open row, runs one CAS-before-RAS cycle and ends with a precharge.

Top module: `pgw_dram_wr`

## Requirements
- R1: After reset, ras_no, cas_no and we_no are high, and req_ready_o is high while no refresh is requested.
- R2: The row is req_addr_i[17:9] and the column is req_addr_i[8:0]. The row is on dram_addr_o when RAS falls. The column is on dram_addr_o when CAS falls for a write, and it stays there while CAS is low.
- R3: Each write CAS fall transfers exactly one nibble, with we_no low. dram_data_o equals that beat's data in the cycle before CAS falls and stays unchanged until CAS rises.
- R4: At least T_RCD cycles pass between a RAS fall and the first write CAS fall under that row.
- R5: CAS stays low for exactly T_CAS cycles on each write.
- R6: The beats after the first in a burst go to column (previous + 1) mod 512 of the same row, with RAS held low. Their address field is ignored.
- R7: A burst whose row equals the open row produces no RAS pulse.
- R8: RAS stays high for at least T_RP cycles before each fall. A burst to a different row than the open one releases RAS and strobes the new row.
- R9: A refresh drops CAS one cycle before RAS, with we_no high. refresh_ack_o then pulses for exactly one cycle. Afterwards no row is open, so the next burst strobes its row anew.
- R10: If a refresh request and a burst's first beat are present in the same idle cycle, the refresh is served first. The beat is not accepted until the refresh has run.
- R11: req_ready_o is high only when idle with no refresh requested, or inside a burst waiting for its next beat. It is never high while CAS is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Write beat valid |
| req_ready_o | output | 1 | Beat accepted when high together with valid |
| req_addr_i | input | 18 | Word address {row, column}, used on the first beat only |
| req_data_i | input | 4 | Nibble to write |
| req_last_i | input | 1 | Marks the final beat of a burst |
| refresh_req_i | input | 1 | Refresh request level |
| refresh_ack_o | output | 1 | One-cycle pulse when the refresh strobes end |
| dram_addr_o | output | 9 | Multiplexed row/column address |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_data_o | output | 4 | Write data nibble |

## Verification
A refresh request and the first beat of a new burst can arrive in the same idle cycle, and the block must pick the refresh. The bench raises both signals on the same clock while the previous row is still open. It checks that ready stays low in that cycle. It also checks that the monitor has counted a completed CAS-before-RAS cycle by the time the beat is accepted. The scoreboard then confirms that the delayed burst strobes its row again rather than taking a page hit.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_ROW, ST_RCD, ST_DSET, ST_CASL, ST_AWAIT, ST_RF_CAS, ST_RF_RAS
  } pgw_state_e;

  typedef enum logic [1:0] {AFT_ROW, AFT_RF, AFT_IDLE} pgw_after_e;
endpackage

// File: rtl/pgw_timer.sv
module pgw_timer #(
  parameter int CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pgw_page_track.sv
module pgw_page_track #(
  parameter int AW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] row_i,
  input  logic [AW-1:0] col_i,
  input  logic          row_load_i,
  input  logic          open_set_i,
  input  logic          close_i,
  input  logic          col_load_i,
  input  logic          col_inc_i,
  output logic [AW-1:0] row_o,
  output logic [AW-1:0] col_o,
  output logic          open_o,
  output logic          hit_o
);
  logic [AW-1:0] row_q, col_q;
  logic          open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q  <= '0;
      col_q  <= '0;
      open_q <= 1'b0;
    end else begin
      if (row_load_i) row_q <= row_i;
      if (row_load_i || close_i) open_q <= 1'b0;
      else if (open_set_i)       open_q <= 1'b1;
      if (col_load_i)     col_q <= col_i;
      else if (col_inc_i) col_q <= col_q + 1'b1;   // wraps inside the row
    end
  end

  assign row_o  = row_q;
  assign col_o  = col_q;
  assign open_o = open_q;
  assign hit_o  = open_q && (row_q == row_i);

  AST_OPEN_NEEDS_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_q) |-> $stable(row_q)) else $error("open without stable row"); // R8
endmodule

// File: rtl/pgw_fsm.sv
module pgw_fsm
  import pgw_pkg::*;
#(
  parameter int DW     = 4,
  parameter int CW     = 3,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2,
  parameter int T_RP   = 3,
  parameter int T_RFSH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_last_i,
  input  logic [DW-1:0] req_data_i,
  input  logic          refresh_req_i,
  input  logic          hit_i,
  input  logic          open_i,
  input  logic          zero_i,
  output logic          req_ready_o,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output logic          row_load_o,
  output logic          open_set_o,
  output logic          close_o,
  output logic          col_load_o,
  output logic          col_inc_o,
  output logic          ack_o,
  output pgw_state_e    state_o,
  output logic [DW-1:0] data_o
);
  localparam logic [CW-1:0] RCD_M1 = CW'(T_RCD - 1);
  localparam logic [CW-1:0] CAS_M1 = CW'(T_CAS - 1);
  localparam logic [CW-1:0] RP_M1  = CW'(T_RP - 1);
  localparam logic [CW-1:0] RF_M1  = CW'(T_RFSH - 1);

  pgw_state_e    state_q, state_d;
  pgw_after_e    after_q, after_d;
  logic [DW-1:0] data_q;
  logic          last_q, ack_q, ack_d, latch;

  assign req_ready_o = ((state_q == ST_IDLE) && !refresh_req_i) || (state_q == ST_AWAIT);

  always_comb begin
    state_d    = state_q;
    after_d    = after_q;
    load_o     = 1'b0;
    load_val_o = '0;
    row_load_o = 1'b0;
    open_set_o = 1'b0;
    close_o    = 1'b0;
    col_load_o = 1'b0;
    col_inc_o  = 1'b0;
    ack_d      = 1'b0;
    latch      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (refresh_req_i) begin   // refresh wins over a new burst
          close_o = 1'b1;
          if (open_i) begin
            state_d = ST_PRE; after_d = AFT_RF; load_o = 1'b1; load_val_o = RP_M1;
          end else begin
            state_d = ST_RF_CAS;
          end
        end else if (req_valid_i) begin
          latch      = 1'b1;
          col_load_o = 1'b1;
          if (hit_i) begin
            state_d = ST_DSET;
          end else begin
            row_load_o = 1'b1;
            if (open_i) begin
              state_d = ST_PRE; after_d = AFT_ROW; load_o = 1'b1; load_val_o = RP_M1;
            end else begin
              state_d = ST_ROW;
            end
          end
        end
      end
      ST_PRE: begin
        if (zero_i) begin
          unique case (after_q)
            AFT_ROW: state_d = ST_ROW;
            AFT_RF:  state_d = ST_RF_CAS;
            default: state_d = ST_IDLE;
          endcase
        end
      end
      ST_ROW: begin
        open_set_o = 1'b1;
        state_d    = ST_RCD;
        load_o     = 1'b1;
        load_val_o = RCD_M1;
      end
      ST_RCD:  if (zero_i) state_d = ST_DSET;
      ST_DSET: begin
        state_d = ST_CASL; load_o = 1'b1; load_val_o = CAS_M1;
      end
      ST_CASL: if (zero_i) state_d = last_q ? ST_IDLE : ST_AWAIT;
      ST_AWAIT: begin
        if (req_valid_i) begin
          latch     = 1'b1;
          col_inc_o = 1'b1;
          state_d   = ST_DSET;
        end
      end
      ST_RF_CAS: begin
        state_d = ST_RF_RAS; load_o = 1'b1; load_val_o = RF_M1;
      end
      ST_RF_RAS: begin
        if (zero_i) begin
          state_d = ST_PRE; after_d = AFT_IDLE; load_o = 1'b1; load_val_o = RP_M1;
          ack_d   = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      after_q <= AFT_IDLE;
      data_q  <= '0;
      last_q  <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      after_q <= after_d;
      ack_q   <= ack_d;
      if (latch) begin
        data_q <= req_data_i;
        last_q <= req_last_i;
      end
    end
  end

  assign ack_o   = ack_q;
  assign state_o = state_q;
  assign data_o  = data_q;

  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o) else $error("ack longer than one cycle"); // R9
  AST_ACK_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !open_i) else $error("row open after refresh"); // R9
endmodule

// File: rtl/pgw_dram_wr.sv
module pgw_dram_wr
  import pgw_pkg::*;
#(
  parameter int AW     = 9,
  parameter int DW     = 4,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2,
  parameter int T_RP   = 3,
  parameter int T_RFSH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [2*AW-1:0] req_addr_i,
  input  logic [DW-1:0]   req_data_i,
  input  logic            req_last_i,
  input  logic            refresh_req_i,
  output logic            refresh_ack_o,
  output logic [AW-1:0]   dram_addr_o,
  output logic            dram_ras_no,
  output logic            dram_cas_no,
  output logic            dram_we_no,
  output logic [DW-1:0]   dram_data_o
);
  localparam int TMAX1 = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int TMAX2 = (T_RP > T_RFSH) ? T_RP : T_RFSH;
  localparam int TMAX  = (TMAX1 > TMAX2) ? TMAX1 : TMAX2;
  localparam int CW    = (TMAX < 2) ? 1 : $clog2(TMAX);
  localparam int PCW   = $clog2(T_RP + 2) + 1;

  pgw_state_e    state;
  logic          load, zero, hit, open_row;
  logic          row_load, open_set, close_row, col_load, col_inc;
  logic [CW-1:0] load_val;
  logic [AW-1:0] row_q, col_q;

  pgw_timer #(.CW(CW)) u_timer (
    .clk_i (clk_i), .rst_ni (rst_ni), .load_i (load), .val_i (load_val), .zero_o (zero)
  );

  pgw_page_track #(.AW(AW)) u_page (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .row_i      (req_addr_i[2*AW-1:AW]),
    .col_i      (req_addr_i[AW-1:0]),
    .row_load_i (row_load),
    .open_set_i (open_set),
    .close_i    (close_row),
    .col_load_i (col_load),
    .col_inc_i  (col_inc),
    .row_o      (row_q),
    .col_o      (col_q),
    .open_o     (open_row),
    .hit_o      (hit)
  );

  pgw_fsm #(
    .DW(DW), .CW(CW), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_RFSH(T_RFSH)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_last_i    (req_last_i),
    .req_data_i    (req_data_i),
    .refresh_req_i (refresh_req_i),
    .hit_i         (hit),
    .open_i        (open_row),
    .zero_i        (zero),
    .req_ready_o   (req_ready_o),
    .load_o        (load),
    .load_val_o    (load_val),
    .row_load_o    (row_load),
    .open_set_o    (open_set),
    .close_o       (close_row),
    .col_load_o    (col_load),
    .col_inc_o     (col_inc),
    .ack_o         (refresh_ack_o),
    .state_o       (state),
    .data_o        (dram_data_o)
  );

  // strobes decoded from registered state only
  assign dram_ras_no = !(open_row || (state == ST_RF_RAS));
  assign dram_cas_no = !((state == ST_CASL) || (state == ST_RF_CAS) || (state == ST_RF_RAS));
  assign dram_we_no  = !((state == ST_DSET) || (state == ST_CASL));
  assign dram_addr_o = ((state == ST_ROW) || (state == ST_RCD)) ? row_q : col_q;

  // cycles RAS has been high, saturating; reset value assumes a precharged device
  logic [PCW-1:0] pre_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        pre_cnt_q <= '1;
    else if (!dram_ras_no)              pre_cnt_q <= '0;
    else if (pre_cnt_q != '1)           pre_cnt_q <= pre_cnt_q + 1'b1;
  end

  AST_PRECHARGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_no) |-> (int'(pre_cnt_q) >= T_RP)) else $error("precharge short"); // R8
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dram_cas_no && !dram_we_no) |-> $stable(dram_data_o)) else $error("data moved"); // R3
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dram_cas_no && !dram_ras_no && !dram_we_no) |-> $stable(dram_addr_o)) else $error("col moved"); // R2
  AST_CBR_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dram_cas_no && dram_ras_no) |=> (!dram_ras_no && !dram_cas_no && dram_we_no)) else $error("cbr order"); // R9
  AST_READY_CAS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> dram_cas_no) else $error("ready during cas"); // R11
endmodule

// File: tb/pgw_dram_wr_bench.sv
module pgw_dram_wr_bench;
  localparam int T_RCD = 2, T_CAS = 2, T_RP = 3, T_RFSH = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_last = 1'b0, refresh_req = 1'b0;
  logic [17:0] req_addr = '0;
  logic [3:0]  req_data = '0;
  logic        ready, ack, ras_n, cas_n, we_n;
  logic [8:0]  daddr;
  logic [3:0]  ddata;

  always #10 clk = ~clk;   // 50 MHz

  pgw_dram_wr u_pgw_dram_wr (
    .clk_i (clk), .rst_ni (rst_n),
    .req_valid_i (req_valid), .req_ready_o (ready), .req_addr_i (req_addr),
    .req_data_i (req_data), .req_last_i (req_last),
    .refresh_req_i (refresh_req), .refresh_ack_o (ack),
    .dram_addr_o (daddr), .dram_ras_no (ras_n), .dram_cas_no (cas_n),
    .dram_we_no (we_n), .dram_data_o (ddata)
  );

  int n_chk = 0, n_bad = 0;
  int ras_falls = 0, refresh_cnt = 0, expect_rf = -1;
  logic [21:0] exp_q[$];   // {row, col, data}

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: one burst, expected writes pushed into the scoreboard
  task automatic send_burst(input logic [8:0] row, input logic [8:0] col,
                            input int n, input logic [3:0] seed, input bit gaps);
    for (int i = 0; i < n; i++) begin
      logic [3:0] d;
      d = seed + 4'(i * 3);
      exp_q.push_back({row, 9'(col + 9'(i)), d});
      req_valid = 1'b1;
      req_addr  = (i == 0) ? {row, col} : {~row, 9'(col ^ 9'h0A5)};  // junk after first, R6
      req_data  = d;
      req_last  = (i == n - 1);
      #1;
      while (!ready) @(negedge clk);
      @(posedge clk);
      if (i == 0 && expect_rf >= 0) begin
        chk(refresh_cnt == expect_rf, "R10 refresh before beat", refresh_cnt, expect_rf);
        expect_rf = -1;
      end
      @(negedge clk);
      req_valid = 1'b0;
      if (gaps && (i % 2 == 0)) repeat (2) @(negedge clk);
    end
  endtask

  task automatic do_refresh();
    refresh_req = 1'b1;
    do @(negedge clk); while (!ack);
    refresh_req = 1'b0;
    @(negedge clk);
    chk(!ack, "R9 ack one cycle", ack, 0);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (T_CAS + 3) @(negedge clk);
  endtask

  // monitor: decodes DRAM pins and compares with the scoreboard
  initial begin
    logic p_ras = 1'b1, p_cas = 1'b1;
    logic [3:0] p_data = '0;
    logic [8:0] open_row = '0, p_addr = '0;
    int hi_cnt = 1000, since_ras = 0, cas_w = 0;
    bit in_wr = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (p_ras && !ras_n) begin
          if (cas_n) begin
            chk(hi_cnt >= T_RP, "R8 precharge", hi_cnt, T_RP);
            open_row = daddr; ras_falls++; since_ras = 0;
          end else begin
            chk(!p_cas && we_n, "R9 cbr order", {p_cas, we_n}, 2'b01);
            refresh_cnt++;
          end
        end
        if (p_cas && !cas_n && !ras_n) begin
          logic [21:0] e;
          chk(!we_n, "R3 we low", we_n, 0);
          chk(ddata == p_data, "R3 setup", ddata, p_data);
          chk(since_ras >= T_RCD, "R4 rcd", since_ras, T_RCD);
          if (exp_q.size() == 0) chk(1'b0, "R3 unexpected write", daddr, 0);
          else begin
            e = exp_q.pop_front();
            chk(open_row == e[21:13], "R2 row", open_row, e[21:13]);
            chk(daddr == e[12:4], "R6 col", daddr, e[12:4]);
            chk(ddata == e[3:0], "R3 data", ddata, e[3:0]);
          end
          in_wr = 1'b1; cas_w = 1;
        end else if (!cas_n && in_wr) begin
          cas_w++;
          chk(ddata == p_data && daddr == p_addr, "R2 hold", {daddr, ddata}, {p_addr, p_data});
        end
        if (!p_cas && cas_n && in_wr) begin
          chk(cas_w == T_CAS, "R5 cas width", cas_w, T_CAS);
          in_wr = 1'b0;
        end
        if (!cas_n && ready) chk(1'b0, "R11 ready in cas", ready, 0);
        if (ras_n) hi_cnt++; else begin hi_cnt = 0; since_ras++; end
      end
      p_ras = ras_n; p_cas = cas_n; p_data = ddata; p_addr = daddr;
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int rf0, rc0;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n, "R1 strobes in reset", {ras_n, cas_n, we_n}, 3'b111);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n && cas_n && we_n, "R1 strobes idle", {ras_n, cas_n, we_n}, 3'b111);
    chk(ready, "R1 ready", ready, 1);

    send_burst(9'h005, 9'h010, 4, 4'h3, 1'b0);
    drain();
    chk(ras_falls == 1, "R2 one row strobe", ras_falls, 1);
    chk(!ras_n, "R6 row kept open", ras_n, 0);

    send_burst(9'h005, 9'h100, 3, 4'hA, 1'b1);   // page hit with gaps
    drain();
    chk(ras_falls == 1, "R7 page hit no ras", ras_falls, 1);

    send_burst(9'h1A3, 9'h1FE, 4, 4'h6, 1'b0);   // miss and column wrap
    drain();
    chk(ras_falls == 2, "R8 miss restrobes", ras_falls, 2);

    rf0 = refresh_cnt;
    do_refresh();
    chk(refresh_cnt == rf0 + 1, "R9 refresh ran", refresh_cnt, rf0 + 1);
    repeat (T_RP + 1) @(negedge clk);
    chk(ras_n, "R9 row closed", ras_n, 1);
    send_burst(9'h1A3, 9'h020, 2, 4'h1, 1'b0);
    drain();
    chk(ras_falls == 3, "R9 reopen after refresh", ras_falls, 3);

    // refresh and new burst in the same idle cycle
    rf0 = refresh_cnt; rc0 = ras_falls;
    refresh_req = 1'b1; req_valid = 1'b1; req_addr = {9'h1A3, 9'h030};
    #1;
    chk(!ready, "R10 ready low with refresh", ready, 0);
    expect_rf = rf0 + 1;
    fork
      begin
        do @(negedge clk); while (!ack);
        refresh_req = 1'b0;
      end
      send_burst(9'h1A3, 9'h030, 2, 4'hC, 1'b0);
    join
    drain();
    chk(ras_falls == rc0 + 1, "R10 row restrobed", ras_falls, rc0 + 1);

    send_burst(9'h000, 9'h000, 8, 4'h0, 1'b1);
    drain();
    chk(exp_q.size() == 0, "R3 scoreboard empty", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule